// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a base to an exponent modulo an odd modulus, all of parameter width `W`. The modular products are formed with a bit-serial radix-2 Montgomery multiplier. The caller writes four operands through one shared data port: base, modulus, exponent and the Montgomery square constant 2^(2W) mod modulus. A 3-bit command code selects which operand the port carries. The caller then issues a run command and waits for the ready flag.

Inside, a sequencer maps the base and the value one into the Montgomery domain. It scans the exponent from its top bit down, squaring on every bit and multiplying by the mapped base where the bit is set. A final product with one returns the result to the ordinary domain. The result remains on the output until a clear command re-arms the engine, which then accepts a new operand set and a new run with no reset.

Top module: `mont_pow`

## Requirements
- R1: After reset is released, ready_o is 0 and result_o is 0.
- R2: With valid_i high, a command code written at a rising clock edge loads data_i into one operand register: code 0 the base, 1 the modulus, 2 the exponent, 3 the square constant 2^(2W) mod modulus.
- R3: A load code applied with valid_i low leaves the operand register unchanged.
- R4: Code 4 (run), applied while the engine is idle, starts a computation. ready_o stays 0 and result_o keeps its previous value until ready_o rises. At that point result_o equals base^exponent mod modulus.
- R5: Whenever ready_o rises, result_o is below the modulus. result_o does not change while ready_o stays high.
- R6: Load commands applied while a computation is running have no effect on that computation's result.
- R7: An exponent of zero yields 1 mod modulus.
- R8: While ready_o is high, code 5 (show) and code 4 (run) leave ready_o high and result_o unchanged.
- R9: Code 6 (clear), applied while ready_o is high, drops ready_o at the next edge and keeps result_o. A new operand set and run then work with no reset.
- R10: At W = 32, base 0x075BCD15, exponent 0x0009FBF1, modulus 0x8000000B and constant 0x1E4 give 0x14B84766. Base 0x010D6231, exponent 0x0006A0A6, modulus 0x8000002D and constant 0x1FA4 give 0x4CE8B4F7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Shared operand data |
| cmd_i | input | 3 | Command code |
| valid_i | input | 1 | Qualifies operand loads |
| ready_o | output | 1 | Result valid |
| result_o | output | W | base^exponent mod modulus |

## Verification
The assertions assume that the modulus is odd, that the base and the square constant are already below the modulus, and that the constant matches the loaded modulus. Under those conditions the Montgomery sums stay below twice the modulus, and every product and the final result fall below it. The bench only draws odd moduli, reduces the base before loading it, and derives the constant from the modulus by repeated modular doubling. No stimulus breaks these assumptions, so a failed assertion points to the datapath rather than the inputs.

// File: rtl/mont_pow_pkg.sv
package mont_pow_pkg;
  typedef enum logic [2:0] {
    CMD_BASE  = 3'd0,
    CMD_MOD   = 3'd1,
    CMD_EXP   = 3'd2,
    CMD_RSQ   = 3'd3,
    CMD_RUN   = 3'd4,
    CMD_SHOW  = 3'd5,
    CMD_CLEAR = 3'd6,
    CMD_NOP   = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV_B, ST_CONV_1, ST_SQR, ST_MUL, ST_EXIT, ST_DONE
  } seq_st_e;

  localparam int unsigned NUM_OPS = 4;
endpackage

// File: rtl/mont_mul.sv
// Bit-serial radix-2 Montgomery product: p = a*b*2^-W mod n
module mont_mul #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] n_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] p_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned AW = W + 2;

  logic [W-1:0]  a_q, b_q, n_q, p_q;
  logic [AW-1:0] acc_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q, done_q;
  logic [AW-1:0] sum_a, sum_n;

  always_comb begin
    sum_a = acc_q + (a_q[0] ? AW'(b_q) : '0);
    sum_n = sum_a + (sum_a[0] ? AW'(n_q) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; n_q <= '0; p_q <= '0;
      acc_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; fin_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        a_q    <= a_i;
        b_q    <= b_i;
        n_q    <= n_i;
        acc_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        fin_q  <= 1'b0;
      end else if (busy_q && !fin_q) begin
        acc_q <= sum_n >> 1;
        a_q   <= a_q >> 1;
        if (cnt_q == CW'(W - 1)) fin_q <= 1'b1;
        else                     cnt_q <= cnt_q + 1'b1;
      end else if (busy_q) begin
        // single conditional subtraction, acc < 2n here
        p_q    <= (acc_q >= AW'(n_q)) ? W'(acc_q - AW'(n_q)) : W'(acc_q);
        done_q <= 1'b1;
        busy_q <= 1'b0;
        fin_q  <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign p_o    = p_q;
endmodule

// File: rtl/mont_pow_ops.sv
// Operand registers, written through the shared port
module mont_pow_ops
  import mont_pow_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmd_e         cmd_i,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  input  logic         lock_i,
  output logic [W-1:0] base_o,
  output logic [W-1:0] mod_o,
  output logic [W-1:0] exp_o,
  output logic [W-1:0] rsq_o
);
  logic [W-1:0] op_q [NUM_OPS];

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        op_q[k] <= '0;
      else if (valid_i && !lock_i && (cmd_i == cmd_e'(k)))
        op_q[k] <= data_i;
    end
  end

  assign base_o = op_q[0];
  assign mod_o  = op_q[1];
  assign exp_o  = op_q[2];
  assign rsq_o  = op_q[3];
endmodule

// File: rtl/mont_pow_seq.sv
// Square-and-multiply sequencer, MSB first
module mont_pow_seq
  import mont_pow_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmd_e         cmd_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] rsq_i,
  input  logic         mul_done_i,
  input  logic [W-1:0] mul_p_i,
  output logic         mul_start_o,
  output logic [W-1:0] mul_a_o,
  output logic [W-1:0] mul_b_o,
  output logic         busy_o,
  output logic         ready_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] ONE = W'(1);

  seq_st_e       st_q;
  logic          issued_q;
  logic [W-1:0]  acc_q, bm_q, res_q;
  logic [IW-1:0] idx_q;
  logic          in_mul;

  assign in_mul = (st_q != ST_IDLE) && (st_q != ST_DONE);

  always_comb begin
    mul_a_o = acc_q;
    mul_b_o = acc_q;
    unique case (st_q)
      ST_CONV_B: begin mul_a_o = base_i; mul_b_o = rsq_i; end
      ST_CONV_1: begin mul_a_o = ONE;    mul_b_o = rsq_i; end
      ST_MUL:    begin mul_a_o = acc_q;  mul_b_o = bm_q;  end
      ST_EXIT:   begin mul_a_o = acc_q;  mul_b_o = ONE;   end
      default:   ;
    endcase
  end

  assign mul_start_o = in_mul && !issued_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; issued_q <= 1'b0;
      acc_q <= '0; bm_q <= '0; res_q <= '0; idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_i == CMD_RUN) begin
          st_q     <= ST_CONV_B;
          idx_q    <= IW'(W - 1);
          issued_q <= 1'b0;
        end
        ST_DONE: if (cmd_i == CMD_CLEAR) st_q <= ST_IDLE;
        default: begin
          if (!issued_q) issued_q <= 1'b1;
          else if (mul_done_i) begin
            issued_q <= 1'b0;
            unique case (st_q)
              ST_CONV_B: begin bm_q <= mul_p_i; st_q <= ST_CONV_1; end
              ST_CONV_1: begin acc_q <= mul_p_i; st_q <= ST_SQR; end
              ST_SQR: begin
                acc_q <= mul_p_i;
                if (exp_i[idx_q])       st_q <= ST_MUL;
                else if (idx_q == '0)   st_q <= ST_EXIT;
                else begin idx_q <= idx_q - 1'b1; st_q <= ST_SQR; end
              end
              ST_MUL: begin
                acc_q <= mul_p_i;
                if (idx_q == '0) st_q <= ST_EXIT;
                else begin idx_q <= idx_q - 1'b1; st_q <= ST_SQR; end
              end
              ST_EXIT: begin res_q <= mul_p_i; st_q <= ST_DONE; end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy_o   = in_mul;
  assign ready_o  = (st_q == ST_DONE);
  assign result_o = res_q;
endmodule

// File: rtl/mont_pow.sv
module mont_pow
  import mont_pow_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic [2:0]   cmd_i,
  input  logic         valid_i,
  output logic         ready_o,
  output logic [W-1:0] result_o
);
  cmd_e         cmd;
  logic [W-1:0] base_w, mod_w, exp_w, rsq_w;
  logic         seq_busy, mul_start, mul_busy, mul_done;
  logic [W-1:0] mul_a, mul_b, mul_p;

  assign cmd = cmd_e'(cmd_i);

  mont_pow_ops #(.W(W)) u_ops (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .data_i(data_i),
    .valid_i(valid_i), .lock_i(seq_busy),
    .base_o(base_w), .mod_o(mod_w), .exp_o(exp_w), .rsq_o(rsq_w)
  );

  mont_pow_seq #(.W(W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd),
    .base_i(base_w), .exp_i(exp_w), .rsq_i(rsq_w),
    .mul_done_i(mul_done), .mul_p_i(mul_p),
    .mul_start_o(mul_start), .mul_a_o(mul_a), .mul_b_o(mul_b),
    .busy_o(seq_busy), .ready_o(ready_o), .result_o(result_o)
  );

  mont_mul #(.W(W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(mul_start),
    .a_i(mul_a), .b_i(mul_b), .n_i(mod_w),
    .busy_o(mul_busy), .done_o(mul_done), .p_o(mul_p)
  );
endmodule

// File: rtl/mont_pow_chk.sv
module mont_pow_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   cmd_i,
  input logic         ready_o,
  input logic [W-1:0] result_o,
  input logic [W-1:0] mod_q,
  input logic [W-1:0] exp_q,
  input logic         busy,
  input logic         mul_busy,
  input logic         mul_done,
  input logic [W-1:0] mul_p
);
  AST_RESULT_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (result_o < mod_q)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(result_o)); // R5
  AST_PRODUCT_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_done |-> (mul_p < mod_q)); // R4
  AST_NOT_READY_WHILE_MUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_busy |-> !ready_o); // R4
  AST_OPS_FROZEN_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(mod_q)); // R6
  AST_OPS_FROZEN_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(exp_q)); // R6
  AST_READY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_i != 3'd6) |=> ready_o); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_i == 3'd6) |=> !ready_o); // R9
endmodule

bind mont_pow mont_pow_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .ready_o(ready_o),
  .result_o(result_o), .mod_q(mod_w), .exp_q(exp_w), .busy(seq_busy),
  .mul_busy(mul_busy), .mul_done(mul_done), .mul_p(mul_p)
);

// File: tb/tb_mont_pow.sv
module tb_mont_pow;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WAIT_MAX = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data = '0;
  logic [2:0]   cmd = 3'd7;
  logic         valid = 1'b0;
  logic         ready;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [W-1:0] last_res = '0;
  longint unsigned rng = 64'h1234_5678_9abc_def1;

  mont_pow #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .cmd_i(cmd),
    .valid_i(valid), .ready_o(ready), .result_o(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic longint unsigned ref_pow(longint unsigned b, longint unsigned e,
                                              longint unsigned n);
    longint unsigned r = 1 % n;
    longint unsigned x = b % n;
    for (int i = 0; i < W; i++) begin
      if (e[i]) r = (r * x) % n;
      x = (x * x) % n;
    end
    return r;
  endfunction

  function automatic longint unsigned ref_rsq(longint unsigned n);
    longint unsigned x = 1 % n;
    for (int i = 0; i < 2*W; i++) x = (x * 2) % n;
    return x;
  endfunction

  function automatic logic [W-1:0] next_rnd();
    rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17;
    return rng[W-1:0];
  endfunction

  task automatic load(input logic [2:0] c, input logic [W-1:0] d, input logic v);
    cmd = c; data = d; valid = v;
    repeat (2) @(negedge clk);
    cmd = 3'd7; valid = 1'b0;
  endtask

  // disturb: loads garbage while running (R6)
  task automatic run(input logic [W-1:0] b, input logic [W-1:0] e,
                     input logic [W-1:0] n, input logic [W-1:0] rsq,
                     input logic [W-1:0] expv, input string req, input bit disturb);
    int k;
    load(3'd0, b, 1'b1);
    load(3'd1, n, 1'b1);
    load(3'd2, e, 1'b1);
    load(3'd3, rsq, 1'b1);
    cmd = 3'd4;
    @(negedge clk);
    k = 0;
    while (!ready && k < WAIT_MAX) begin
      chk(result == last_res, "R4 result held while busy", result, last_res);
      if (disturb && k == 40) begin cmd = 3'd0; data = ~b; valid = 1'b1; end
      if (disturb && k == 42) begin cmd = 3'd2; data = 32'h5; end
      if (disturb && k == 44) begin cmd = 3'd4; valid = 1'b0; end
      @(negedge clk);
      k++;
    end
    chk(ready, "R4 ready rises", ready, 1);
    chk(result == expv, req, result, expv);
    last_res = result;
    cmd = 3'd5;
    repeat (2) begin
      @(negedge clk);
      chk(ready && result == expv, "R8 show keeps result", result, expv);
    end
    cmd = 3'd4;
    repeat (2) begin
      @(negedge clk);
      chk(ready && result == expv, "R8 run ignored while ready", result, expv);
    end
    cmd = 3'd6;
    @(negedge clk);
    chk(!ready, "R9 clear drops ready", ready, 0);
    chk(result == expv, "R9 result kept after clear", result, expv);
    cmd = 3'd7;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ready, "R1 ready after reset", ready, 0);
    chk(result == '0, "R1 result after reset", result, 0);

    // R10 fixed vectors (R2 load codes 0..3)
    run(32'h075BCD15, 32'h0009FBF1, 32'h8000000B, 32'h1E4, 32'h14B84766, "R10 vector 1", 0);
    run(32'h010D6231, 32'h0006A0A6, 32'h8000002D, 32'h1FA4, 32'h4CE8B4F7, "R10 vector 2 R9 no reset", 0);

    // R7 zero exponent
    run(32'h5, 32'h0, 32'h8000000B, 32'(ref_rsq(64'h8000000B)), 32'h1, "R7 zero exponent", 0);

    // R3: second base load with valid low must be ignored
    begin
      logic [W-1:0] n3 = 32'd1000003;
      load(3'd0, 32'd9, 1'b1);
      run(32'd7, 32'd3, n3, 32'(ref_rsq(n3)), 32'(ref_pow(7, 3, n3)), "R2 small case", 0);
      load(3'd0, 32'd7, 1'b1);
      load(3'd0, 32'd9, 1'b0);
      cmd = 3'd4;
      @(negedge clk);
      while (!ready) @(negedge clk);
      chk(result == 32'(ref_pow(7, 3, n3)), "R3 ignored load", result, ref_pow(7, 3, n3));
      last_res = result;
      cmd = 3'd6;
      @(negedge clk);
      cmd = 3'd7;
      @(negedge clk);
    end

    // R4, R6: pseudo-random operand sets, some disturbed mid-run
    for (int t = 0; t < 5; t++) begin
      logic [W-1:0] n, b, e;
      n = next_rnd() | 32'h1;
      if (n == 32'h1) n = 32'h8000000B;
      b = 32'(longint'(next_rnd()) % longint'(n));
      e = next_rnd();
      run(b, e, n, 32'(ref_rsq(n)), 32'(ref_pow(b, e, n)),
          (t % 2 == 1) ? "R6 loads during run ignored" : "R4 random operands", t % 2 == 1);
    end

    // R5 exponent one returns the base
    run(32'h1234567, 32'h1, 32'h8000002D, 32'(ref_rsq(64'h8000002D)), 32'h1234567, "R5 exponent one", 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule